// File: doc/BRIEF.md
# Bank-switched dual-port memory

This block is a two-port synchronous word memory split into four independent banks, plus a small mailbox region that both ports share. The left and right ports each have their own chip enables, read/write control, upper and lower byte enables, bank address, word address and write data. Ownership is static: an external per-bank owner input gives each bank to exactly one port. A port reads or writes only the banks it owns. An attempt on a bank owned by the other port does nothing and raises a one-cycle violation flag on the port that made it.

A mailbox-select input on each port sends an access to the shared mailbox instead of the banks. Both ports can always reach the mailbox, so two processors can exchange short messages there without changing bank ownership. Each byte lane can be written on its own, which allows 8-bit or 16-bit accesses. A port that is not selected stays in standby. The bank depth and the mailbox depth are parameters, so a simulation can use a small memory.

Top module: `bank_switch_dpram`

## Requirements
- R1: While reset is held low, and in the first cycle after reset is released, both `*_rdata` outputs read zero and both `*_viol` outputs are low. Reset does not clear the memory contents.
- R2: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1. The three other combinations leave it in standby: it writes nothing, its `rdata` reads zero and its `viol` stays low in the next cycle.
- R3: A selected read (`we_n`=1) returns the addressed word on `rdata` one clock after the address is presented. Bits 15:8 read as zero when `ub_n`=1, and bits 7:0 read as zero when `lb_n`=1.
- R4: A selected write (`we_n`=0) stores `wdata[15:8]` only when `ub_n`=0 and `wdata[7:0]` only when `lb_n`=0. The other byte keeps its old value. `rdata` reads zero in the cycle after a write.
- R5: Bit b of `bank_own` gives bank b to the left port when 0 and to the right port when 1. A bank access by the port that does not own the bank writes nothing. In the next cycle it returns zero on `rdata` and sets that port's `viol` high for that one cycle.
- R6: `bank_own` may change in any cycle. A bank keeps its contents across an ownership change, and the new owner reads what the old owner wrote.
- R7: When `mbox_n`=0 on a selected port, the access goes to the shared mailbox entry chosen by the lowest MBOX_AW bits of `addr`. The bank address and the higher address bits are ignored. The ownership check does not apply, so `viol` stays low. The mailbox storage is separate from the banks.
- R8: When both ports write the same mailbox entry in the same cycle, a byte lane enabled by both ports takes the left port's data. A lane enabled by only one port takes that port's data.
- R9: `bank` selects one of four banks. The same word address in different banks names different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_own | input | 4 | Per-bank owner: 0 = left port, 1 = right port |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_we_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| l_ub_n | input | 1 | Left upper byte enable (bits 15:8), active low |
| l_lb_n | input | 1 | Left lower byte enable (bits 7:0), active low |
| l_mbox_n | input | 1 | Left mailbox select, 0 = mailbox, 1 = banks |
| l_bank | input | 2 | Left bank address |
| l_addr | input | WORD_AW | Left word address within the bank |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, valid one cycle after the request |
| l_viol | output | 1 | Left ownership-violation pulse |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_we_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| r_ub_n | input | 1 | Right upper byte enable (bits 15:8), active low |
| r_lb_n | input | 1 | Right lower byte enable (bits 7:0), active low |
| r_mbox_n | input | 1 | Right mailbox select, 0 = mailbox, 1 = banks |
| r_bank | input | 2 | Right bank address |
| r_addr | input | WORD_AW | Right word address within the bank |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, valid one cycle after the request |
| r_viol | output | 1 | Right ownership-violation pulse |

## Verification
The first pass fills every bank word and every mailbox entry from the left port with a pattern that encodes its location. Reading the same word address in each bank then shows whether the bank decode keeps the banks apart. Directed patterns cover the following cases:
- single-lane writes, which separate the upper-lane enable from the lower-lane enable;
- each of the three deselect combinations, which shows the chip enables are decoded as a pair rather than through one pin;
- writes from the port that does not own the bank, followed by a read from the owner, which shows a blocked write left no trace;
- an ownership flip in each direction, which shows the contents survive the change;
- mailbox accesses with differing high address bits, and a same-entry write from both ports, which expose address aliasing and the lane priority.

A long seeded random run then mixes all of these with frequent ownership changes against the bench's own model.

// File: rtl/bsdp_pkg.sv
// Package: shared constants and types for the bank-switched dual-port memory.
// Assumes a 16-bit word made of two 8-bit byte lanes; lane 1 is bits 15:8.
package bsdp_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    // Where a port's registered read result comes from.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BANK = 2'd1,
        SRC_MBOX = 2'd2
    } src_e;
endpackage

// File: rtl/bsdp_port_ctrl.sv
// Module: per-port request decoder.
// Works out whether the port is selected, whether it targets the mailbox or
// a bank, and whether it owns that bank. It gives the banks and the mailbox
// their hit strobes and registers the read source, the lane mask and the
// violation pulse for the following cycle.
// Assumes that bank_own bit b = 1 means the right port owns bank b.
module bsdp_port_ctrl
    import bsdp_pkg::*;
#(
    parameter int BANK_AW  = 2,
    parameter bit IS_RIGHT = 1'b0,
    localparam int NB      = 1 << BANK_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NB-1:0]      bank_own,
    input  logic               ce0_n,
    input  logic               ce1,
    input  logic               we_n,
    input  logic               ub_n,
    input  logic               lb_n,
    input  logic               mbox_n,
    input  logic [BANK_AW-1:0] bank,
    output logic [NB-1:0]      hit_bank,
    output logic               hit_mbox,
    output logic               is_wr,
    output logic [LANES-1:0]   lane,
    output src_e               src_q,
    output logic [BANK_AW-1:0] bank_q,
    output logic [LANES-1:0]   lane_q,
    output logic               viol_q
);
    logic sel;
    logic owned;
    logic to_bank;
    logic to_mbox;
    logic blocked;

    // Decode selection, the target region and bank ownership for this port.
    always_comb begin
        sel     = !ce0_n && ce1;
        owned   = (bank_own[bank] == IS_RIGHT);
        to_mbox = sel && !mbox_n;
        to_bank = sel && mbox_n && owned;
        blocked = sel && mbox_n && !owned;
    end

    // One hit strobe per bank, raised only for an owned bank access.
    for (genvar b = 0; b < NB; b++) begin : g_hit
        assign hit_bank[b] = to_bank && (bank == BANK_AW'(b));
    end

    assign hit_mbox = to_mbox;
    assign is_wr    = !we_n;
    assign lane     = {!ub_n, !lb_n};

    // Register the read source, the lane mask and the violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_NONE;
            bank_q <= '0;
            lane_q <= '0;
            viol_q <= 1'b0;
        end else begin
            viol_q <= blocked;
            bank_q <= bank;
            lane_q <= lane;
            if (!we_n)        src_q <= SRC_NONE;
            else if (to_mbox) src_q <= SRC_MBOX;
            else if (to_bank) src_q <= SRC_BANK;
            else              src_q <= SRC_NONE;
        end
    end
endmodule

// File: rtl/bsdp_bank.sv
// Module: one memory bank with byte-lane writes and a registered read.
// The current owner's request is steered in, so the bank has a single
// access path. Assumes the port decoders raise a hit only for an owned bank.
module bsdp_bank
    import bsdp_pkg::*;
#(
    parameter int WORD_AW = 6,
    localparam int DEPTH  = 1 << WORD_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               own,
    input  logic               l_hit,
    input  logic               l_wr,
    input  logic [LANES-1:0]   l_lane,
    input  logic [WORD_AW-1:0] l_addr,
    input  logic [DATA_W-1:0]  l_wdata,
    input  logic               r_hit,
    input  logic               r_wr,
    input  logic [LANES-1:0]   r_lane,
    input  logic [WORD_AW-1:0] r_addr,
    input  logic [DATA_W-1:0]  r_wdata,
    output logic [DATA_W-1:0]  rd_q
);
    logic [DATA_W-1:0]  mem [DEPTH];
    logic               s_hit;
    logic               s_wr;
    logic [LANES-1:0]   s_lane;
    logic [WORD_AW-1:0] s_addr;
    logic [DATA_W-1:0]  s_wdata;

    // Steer the owning port's request onto the bank.
    always_comb begin
        s_hit   = own ? r_hit   : l_hit;
        s_wr    = own ? r_wr    : l_wr;
        s_lane  = own ? r_lane  : l_lane;
        s_addr  = own ? r_addr  : l_addr;
        s_wdata = own ? r_wdata : l_wdata;
    end

    // Write the enabled byte lanes, or capture the addressed word on a read.
    always_ff @(posedge clk) begin
        if (s_hit && s_wr) begin
            for (int i = 0; i < LANES; i++) begin
                if (s_lane[i]) mem[s_addr][i*LANE_W +: LANE_W] <= s_wdata[i*LANE_W +: LANE_W];
            end
        end
        if (s_hit && !s_wr) rd_q <= mem[s_addr];
    end

    // R5: only the owning port's decoder may ever reach this bank.
    a_r5_owner_only_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !((l_hit && own) || (r_hit && !own)));
endmodule

// File: rtl/bsdp_mailbox.sv
// Module: shared mailbox with two write ports and two registered reads.
// Both ports can reach it at any time. When both ports write the same entry
// in one cycle, a lane that both enable takes the left port's data.
// A read returns the contents from before any write in the same cycle.
module bsdp_mailbox
    import bsdp_pkg::*;
#(
    parameter int MBOX_AW = 6,
    localparam int MDEPTH = 1 << MBOX_AW
) (
    input  logic               clk,
    input  logic               l_hit,
    input  logic               l_wr,
    input  logic [LANES-1:0]   l_lane,
    input  logic [MBOX_AW-1:0] l_addr,
    input  logic [DATA_W-1:0]  l_wdata,
    input  logic               r_hit,
    input  logic               r_wr,
    input  logic [LANES-1:0]   r_lane,
    input  logic [MBOX_AW-1:0] r_addr,
    input  logic [DATA_W-1:0]  r_wdata,
    output logic [DATA_W-1:0]  l_rd_q,
    output logic [DATA_W-1:0]  r_rd_q
);
    logic [DATA_W-1:0] mem [MDEPTH];

    // Apply the right port's writes first, so the left port's later ones win.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (r_hit && r_wr && r_lane[i])
                mem[r_addr][i*LANE_W +: LANE_W] <= r_wdata[i*LANE_W +: LANE_W];
            if (l_hit && l_wr && l_lane[i])
                mem[l_addr][i*LANE_W +: LANE_W] <= l_wdata[i*LANE_W +: LANE_W];
        end
    end

    // Capture each port's read word from the contents before this cycle's writes.
    always_ff @(posedge clk) begin
        if (l_hit && !l_wr) l_rd_q <= mem[l_addr];
        if (r_hit && !r_wr) r_rd_q <= mem[r_addr];
    end
endmodule

// File: rtl/bsdp_rdmux.sv
// Module: per-port read-data selector.
// Chooses the captured bank word or mailbox word from the registered source
// and zeroes the lanes that were not enabled. Assumes all inputs are
// registered, which keeps the read latency at one clock.
module bsdp_rdmux
    import bsdp_pkg::*;
#(
    parameter int BANK_AW = 2,
    localparam int NB     = 1 << BANK_AW
) (
    input  src_e                       src_q,
    input  logic [BANK_AW-1:0]         bank_q,
    input  logic [LANES-1:0]           lane_q,
    input  logic [NB-1:0][DATA_W-1:0]  bank_rd,
    input  logic [DATA_W-1:0]          mbox_rd,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] word;

    // Pick the source word, then mask it by the lanes that were enabled.
    always_comb begin
        case (src_q)
            SRC_BANK: word = bank_rd[bank_q];
            SRC_MBOX: word = mbox_rd;
            default:  word = '0;
        endcase
        for (int i = 0; i < LANES; i++) begin
            rdata[i*LANE_W +: LANE_W] = lane_q[i] ? word[i*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/bank_switch_dpram.sv
// Module: top of the bank-switched dual-port memory.
// Contains two port decoders, one bank per bank address value (built in a
// generate loop), the shared mailbox and two read selectors. Assumes the
// owner input is steady across a clock edge; it may change between edges.
module bank_switch_dpram
    import bsdp_pkg::*;
#(
    parameter int BANK_AW  = 2,
    parameter int WORD_AW  = 6,
    parameter int MBOX_AW  = 6,
    localparam int NB      = 1 << BANK_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NB-1:0]      bank_own,
    input  logic               l_ce0_n,
    input  logic               l_ce1,
    input  logic               l_we_n,
    input  logic               l_ub_n,
    input  logic               l_lb_n,
    input  logic               l_mbox_n,
    input  logic [BANK_AW-1:0] l_bank,
    input  logic [WORD_AW-1:0] l_addr,
    input  logic [DATA_W-1:0]  l_wdata,
    output logic [DATA_W-1:0]  l_rdata,
    output logic               l_viol,
    input  logic               r_ce0_n,
    input  logic               r_ce1,
    input  logic               r_we_n,
    input  logic               r_ub_n,
    input  logic               r_lb_n,
    input  logic               r_mbox_n,
    input  logic [BANK_AW-1:0] r_bank,
    input  logic [WORD_AW-1:0] r_addr,
    input  logic [DATA_W-1:0]  r_wdata,
    output logic [DATA_W-1:0]  r_rdata,
    output logic               r_viol
);
    logic [NB-1:0]             l_hit_bank, r_hit_bank;
    logic                      l_hit_mbox, r_hit_mbox;
    logic                      l_is_wr, r_is_wr;
    logic [LANES-1:0]          l_lane, r_lane;
    src_e                      l_src_q, r_src_q;
    logic [BANK_AW-1:0]        l_bank_q, r_bank_q;
    logic [LANES-1:0]          l_lane_q, r_lane_q;
    logic [NB-1:0][DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0]         l_mbox_rd, r_mbox_rd;
    logic                      l_sel, r_sel;

    assign l_sel = !l_ce0_n && l_ce1;
    assign r_sel = !r_ce0_n && r_ce1;

    bsdp_port_ctrl #(.BANK_AW(BANK_AW), .IS_RIGHT(1'b0)) u_lctl (
        .clk(clk), .rst_n(rst_n), .bank_own(bank_own),
        .ce0_n(l_ce0_n), .ce1(l_ce1), .we_n(l_we_n), .ub_n(l_ub_n), .lb_n(l_lb_n),
        .mbox_n(l_mbox_n), .bank(l_bank),
        .hit_bank(l_hit_bank), .hit_mbox(l_hit_mbox), .is_wr(l_is_wr), .lane(l_lane),
        .src_q(l_src_q), .bank_q(l_bank_q), .lane_q(l_lane_q), .viol_q(l_viol)
    );

    bsdp_port_ctrl #(.BANK_AW(BANK_AW), .IS_RIGHT(1'b1)) u_rctl (
        .clk(clk), .rst_n(rst_n), .bank_own(bank_own),
        .ce0_n(r_ce0_n), .ce1(r_ce1), .we_n(r_we_n), .ub_n(r_ub_n), .lb_n(r_lb_n),
        .mbox_n(r_mbox_n), .bank(r_bank),
        .hit_bank(r_hit_bank), .hit_mbox(r_hit_mbox), .is_wr(r_is_wr), .lane(r_lane),
        .src_q(r_src_q), .bank_q(r_bank_q), .lane_q(r_lane_q), .viol_q(r_viol)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bsdp_bank #(.WORD_AW(WORD_AW)) u_bank (
            .clk(clk), .rst_n(rst_n), .own(bank_own[b]),
            .l_hit(l_hit_bank[b]), .l_wr(l_is_wr), .l_lane(l_lane),
            .l_addr(l_addr), .l_wdata(l_wdata),
            .r_hit(r_hit_bank[b]), .r_wr(r_is_wr), .r_lane(r_lane),
            .r_addr(r_addr), .r_wdata(r_wdata),
            .rd_q(bank_rd[b])
        );
    end

    bsdp_mailbox #(.MBOX_AW(MBOX_AW)) u_mbox (
        .clk(clk),
        .l_hit(l_hit_mbox), .l_wr(l_is_wr), .l_lane(l_lane),
        .l_addr(l_addr[MBOX_AW-1:0]), .l_wdata(l_wdata),
        .r_hit(r_hit_mbox), .r_wr(r_is_wr), .r_lane(r_lane),
        .r_addr(r_addr[MBOX_AW-1:0]), .r_wdata(r_wdata),
        .l_rd_q(l_mbox_rd), .r_rd_q(r_mbox_rd)
    );

    bsdp_rdmux #(.BANK_AW(BANK_AW)) u_lmux (
        .src_q(l_src_q), .bank_q(l_bank_q), .lane_q(l_lane_q),
        .bank_rd(bank_rd), .mbox_rd(l_mbox_rd), .rdata(l_rdata)
    );

    bsdp_rdmux #(.BANK_AW(BANK_AW)) u_rmux (
        .src_q(r_src_q), .bank_q(r_bank_q), .lane_q(r_lane_q),
        .bank_rd(bank_rd), .mbox_rd(r_mbox_rd), .rdata(r_rdata)
    );

    // R2: a port in standby is quiet in the next cycle.
    a_r2_standby_quiet_l: assert property (@(posedge clk) disable iff (!rst_n)
        !l_sel |=> (l_rdata == '0) && !l_viol);
    a_r2_standby_quiet_r: assert property (@(posedge clk) disable iff (!rst_n)
        !r_sel |=> (r_rdata == '0) && !r_viol);

    // R5: a violation cycle carries no read data.
    a_r5_viol_no_data_l: assert property (@(posedge clk) disable iff (!rst_n)
        l_viol |-> (l_rdata == '0));
    a_r5_viol_no_data_r: assert property (@(posedge clk) disable iff (!rst_n)
        r_viol |-> (r_rdata == '0));

    // R4: the cycle after a write returns no data.
    a_r4_write_no_data_l: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_we_n) |=> (l_rdata == '0));
    a_r4_write_no_data_r: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && !r_we_n) |=> (r_rdata == '0));

    // R3: a disabled upper lane reads zero.
    a_r3_upper_masked_l: assert property (@(posedge clk) disable iff (!rst_n)
        l_ub_n |=> (l_rdata[15:8] == 8'h00));
    a_r3_upper_masked_r: assert property (@(posedge clk) disable iff (!rst_n)
        r_ub_n |=> (r_rdata[15:8] == 8'h00));

    // R7: a mailbox access never raises a violation.
    a_r7_mbox_no_viol_l: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_mbox_n) |=> !l_viol);
    a_r7_mbox_no_viol_r: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && !r_mbox_n) |=> !r_viol);
endmodule

// File: tb/test_bank_switch_dpram.sv
// Bench: directed corner cases followed by seeded random traffic, checked
// against a behavioural model of the banks and the mailbox.
module test_bank_switch_dpram;
    localparam int WA = 5;
    localparam int MA = 3;
    localparam int ND = 1 << WA;
    localparam int MD = 1 << MA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] b_own = 4'h0;
    logic p_ce0_n [2];
    logic p_ce1   [2];
    logic p_we_n  [2];
    logic p_ub_n  [2];
    logic p_lb_n  [2];
    logic p_mbox_n[2];
    logic [1:0]    p_bank [2];
    logic [WA-1:0] p_addr [2];
    logic [15:0]   p_wdata[2];
    logic [15:0]   p_rdata[2];
    logic          p_viol [2];

    logic [15:0] m_bank [4][ND];
    logic [15:0] m_mbox [MD];
    logic [15:0] e_rd [2];
    logic        e_vi [2];
    string       e_tag [2];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int unsigned seed_val;

    always #2 clk = ~clk;

    bank_switch_dpram #(.BANK_AW(2), .WORD_AW(WA), .MBOX_AW(MA)) i_bank_switch_dpram (
        .clk(clk), .rst_n(rst_n), .bank_own(b_own),
        .l_ce0_n(p_ce0_n[0]), .l_ce1(p_ce1[0]), .l_we_n(p_we_n[0]), .l_ub_n(p_ub_n[0]),
        .l_lb_n(p_lb_n[0]), .l_mbox_n(p_mbox_n[0]), .l_bank(p_bank[0]), .l_addr(p_addr[0]),
        .l_wdata(p_wdata[0]), .l_rdata(p_rdata[0]), .l_viol(p_viol[0]),
        .r_ce0_n(p_ce0_n[1]), .r_ce1(p_ce1[1]), .r_we_n(p_we_n[1]), .r_ub_n(p_ub_n[1]),
        .r_lb_n(p_lb_n[1]), .r_mbox_n(p_mbox_n[1]), .r_bank(p_bank[1]), .r_addr(p_addr[1]),
        .r_wdata(p_wdata[1]), .r_rdata(p_rdata[1]), .r_viol(p_viol[1])
    );

    function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic ub_n, input logic lb_n);
        return {ub_n ? 8'h00 : d[15:8], lb_n ? 8'h00 : d[7:0]};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic ub_n, input logic lb_n);
        return {ub_n ? old[15:8] : d[15:8], lb_n ? old[7:0] : d[7:0]};
    endfunction

    function automatic bit sel_of(input int p);
        return !p_ce0_n[p] && p_ce1[p];
    endfunction

    // Expected read data and violation for port p, from the model before writes.
    task automatic model_read(input int p);
        e_rd[p] = 16'h0;
        e_vi[p] = 1'b0;
        if (sel_of(p)) begin
            if (!p_mbox_n[p]) begin
                if (p_we_n[p]) e_rd[p] = lane_mask(m_mbox[p_addr[p][MA-1:0]], p_ub_n[p], p_lb_n[p]);
            end else if (b_own[p_bank[p]] == p[0]) begin
                if (p_we_n[p]) e_rd[p] = lane_mask(m_bank[p_bank[p]][p_addr[p]], p_ub_n[p], p_lb_n[p]);
            end else begin
                e_vi[p] = 1'b1;
            end
        end
    endtask

    task automatic model_write(input int p);
        if (sel_of(p) && !p_we_n[p]) begin
            if (!p_mbox_n[p])
                m_mbox[p_addr[p][MA-1:0]] = merge(m_mbox[p_addr[p][MA-1:0]], p_wdata[p], p_ub_n[p], p_lb_n[p]);
            else if (b_own[p_bank[p]] == p[0])
                m_bank[p_bank[p]][p_addr[p]] = merge(m_bank[p_bank[p]][p_addr[p]], p_wdata[p], p_ub_n[p], p_lb_n[p]);
        end
    endtask

    function automatic string tag_of(input int p);
        if (!sel_of(p)) return "R2";
        if (!p_mbox_n[p]) begin
            if (sel_of(1 - p) && !p_mbox_n[1 - p] && !p_we_n[0] && !p_we_n[1]
                && p_addr[0][MA-1:0] == p_addr[1][MA-1:0]) return "R8";
            return "R7";
        end
        if (b_own[p_bank[p]] != p[0]) return "R5";
        if (!p_we_n[p]) return "R4";
        return "R3";
    endfunction

    // Apply the current inputs for one clock, then compare both ports.
    task automatic cycle(input string ovr);
        for (int p = 0; p < 2; p++) begin
            model_read(p);
            e_tag[p] = (ovr != "") ? ovr : tag_of(p);
        end
        model_write(1);
        model_write(0);
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            n_chk++;
            if (p_rdata[p] !== e_rd[p]) begin
                n_fail++;
                $display("FAIL %s port%0d rdata actual=%h expected=%h", e_tag[p], p, p_rdata[p], e_rd[p]);
            end
            n_chk++;
            if (p_viol[p] !== e_vi[p]) begin
                n_fail++;
                $display("FAIL %s port%0d viol actual=%b expected=%b", e_tag[p], p, p_viol[p], e_vi[p]);
            end
        end
    endtask

    task automatic idle(input int p);
        p_ce0_n[p] = 1'b1; p_ce1[p] = 1'b0; p_we_n[p] = 1'b1;
        p_ub_n[p] = 1'b0; p_lb_n[p] = 1'b0; p_mbox_n[p] = 1'b1;
    endtask

    task automatic rd(input int p, input logic mb_n, input logic [1:0] bk, input logic [WA-1:0] a);
        p_ce0_n[p] = 1'b0; p_ce1[p] = 1'b1; p_we_n[p] = 1'b1;
        p_ub_n[p] = 1'b0; p_lb_n[p] = 1'b0; p_mbox_n[p] = mb_n;
        p_bank[p] = bk; p_addr[p] = a;
    endtask

    task automatic wr(input int p, input logic mb_n, input logic [1:0] bk, input logic [WA-1:0] a,
                      input logic ub_n, input logic lb_n, input logic [15:0] d);
        p_ce0_n[p] = 1'b0; p_ce1[p] = 1'b1; p_we_n[p] = 1'b0;
        p_ub_n[p] = ub_n; p_lb_n[p] = lb_n; p_mbox_n[p] = mb_n;
        p_bank[p] = bk; p_addr[p] = a; p_wdata[p] = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        seed_val = $urandom(32'd20240611);
        for (int p = 0; p < 2; p++) begin
            p_bank[p] = 2'd0; p_addr[p] = '0; p_wdata[p] = 16'h0;
        end
        // R1: during reset a selected read still shows zero outputs.
        rd(0, 1'b1, 2'd0, '0);
        rd(1, 1'b1, 2'd1, '0);
        b_own = 4'b1010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            n_chk++;
            if (p_rdata[p] !== 16'h0 || p_viol[p] !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 port%0d reset actual=%h/%b expected=0000/0", p, p_rdata[p], p_viol[p]);
            end
        end
        idle(0); idle(1);
        rst_n = 1'b1;
        cycle("R1");

        // Fill every bank word and mailbox entry from the left port.
        b_own = 4'h0;
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < ND; a++) begin
                wr(0, 1'b1, 2'(b), WA'(a), 1'b0, 1'b0, {4'(b), 4'h5, 8'(a)});
                cycle("R4");
            end
        end
        for (int a = 0; a < MD; a++) begin
            wr(0, 1'b0, 2'd3, WA'(a), 1'b0, 1'b0, {8'hA0, 8'(a)});
            cycle("R7");
        end
        idle(0);

        // R9: the same word address in each bank names a different word.
        for (int b = 0; b < 4; b++) begin
            rd(0, 1'b1, 2'(b), WA'(7));
            cycle("R9");
        end

        // R4: single-lane writes, then read back.
        wr(0, 1'b1, 2'd1, WA'(4), 1'b0, 1'b1, 16'hBEEF);
        cycle("R4");
        wr(0, 1'b1, 2'd1, WA'(5), 1'b1, 1'b0, 16'hCAFE);
        cycle("R4");
        rd(0, 1'b1, 2'd1, WA'(4));
        cycle("R4");
        rd(0, 1'b1, 2'd1, WA'(5));
        cycle("R4");
        // R3: read with only the lower lane enabled.
        rd(0, 1'b1, 2'd2, WA'(9));
        p_ub_n[0] = 1'b1;
        cycle("R3");

        // R5: the right port tries bank 2 while the left port owns it.
        wr(1, 1'b1, 2'd2, WA'(3), 1'b0, 1'b0, 16'h1111);
        cycle("R5");
        rd(1, 1'b1, 2'd2, WA'(3));
        cycle("R5");
        idle(1);
        rd(0, 1'b1, 2'd2, WA'(3));
        cycle("R5");
        // R5: two violations back to back, then a legal access.
        b_own = 4'hF;
        rd(0, 1'b1, 2'd0, WA'(1));
        cycle("R5");
        wr(0, 1'b1, 2'd3, WA'(1), 1'b0, 1'b0, 16'h2222);
        cycle("R5");
        idle(0);
        rd(1, 1'b1, 2'd3, WA'(1));
        cycle("R5");

        // R6: ownership flips in both directions keep the contents.
        b_own = 4'b0010;
        wr(1, 1'b1, 2'd1, WA'(6), 1'b0, 1'b0, 16'h6A6A);
        cycle("R6");
        b_own = 4'b0000;
        idle(1);
        rd(0, 1'b1, 2'd1, WA'(6));
        cycle("R6");
        b_own = 4'b1000;
        rd(1, 1'b1, 2'd3, WA'(7));
        cycle("R6");
        idle(1);

        // R2: each deselect combination with a write attempt, then read back.
        for (int c = 0; c < 3; c++) begin
            wr(0, 1'b1, 2'd0, WA'(3), 1'b0, 1'b0, 16'hDEAD);
            p_ce0_n[0] = (c != 1);
            p_ce1[0]   = (c == 0);
            cycle("R2");
        end
        rd(0, 1'b1, 2'd0, WA'(3));
        cycle("R2");

        // R8: both ports write mailbox entry 2 in the same cycle.
        wr(0, 1'b0, 2'd0, WA'(2), 1'b0, 1'b1, 16'h1234);
        wr(1, 1'b0, 2'd3, WA'(2), 1'b0, 1'b0, 16'h5678);
        cycle("R8");
        rd(0, 1'b0, 2'd1, WA'(2));
        rd(1, 1'b0, 2'd2, WA'(2));
        cycle("R8");

        // R7: mailbox aliases on the high address bits and ignores ownership.
        b_own = 4'hF;
        wr(0, 1'b0, 2'd1, WA'(5), 1'b0, 1'b0, 16'h7777);
        idle(1);
        cycle("R7");
        rd(0, 1'b0, 2'd2, WA'(5 + MD));
        rd(1, 1'b0, 2'd0, WA'(5 + 2 * MD));
        cycle("R7");
        rd(1, 1'b1, 2'd1, WA'(5));
        idle(0);
        cycle("R7");

        // Random traffic with frequent ownership changes.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 8 == 0) b_own = 4'($urandom);
            for (int p = 0; p < 2; p++) begin
                int k;
                k = int'($urandom % 100);
                p_ce0_n[p]  = 1'b0;
                p_ce1[p]    = 1'b1;
                if (k < 10) begin
                    p_ce0_n[p] = (k % 3 != 1);
                    p_ce1[p]   = (k % 3 == 0);
                end
                p_mbox_n[p] = ($urandom % 5 != 0);
                p_we_n[p]   = 1'($urandom);
                p_ub_n[p]   = ($urandom % 4 == 0);
                p_lb_n[p]   = ($urandom % 4 == 0);
                p_bank[p]   = 2'($urandom);
                p_addr[p]   = WA'($urandom);
                p_wdata[p]  = 16'($urandom);
            end
            cycle("");
        end
        idle(0); idle(1);
        cycle("R2");
        finish_run();
    end
endmodule